// File: doc/BRIEF.md
# Event Flag and Enable Register with Set/Clear Aliases

This block is a single 32-bit control and status word for a two-wire serial bus controller. It latches one-cycle event pulses from the transfer sequencer into sticky flag bits and holds a matching enable bit for each flag. It drives one registered interrupt line, which is high while any flag is set together with its enable.

Software reaches the word through three aliases on a simple register bus. The base address reads and writes the whole word. Base+4 sets the bits written as one. Base+8 clears the bits written as one. Because of these aliases, software never has to do a read-modify-write. An interrupt handler acknowledges the events it saw by writing those flag bits back to the clear alias. A hardware event arriving in the same cycle as a clear of its bit keeps the flag set, so no event is lost. Bit 31 is a self-clearing soft reset that returns the flags and the enables to their idle value.

Top module: `evt_status_csr`

## Requirements
- R1: After the synchronous active-low reset, all flags, all enables and `irq` are 0, and a read of the base address returns 0.
- R2: A pulse on `evt_pulse[i]` sets flag bit i (read at bit i) at the next clock edge. The event meanings are: bit 7 bus free, bit 6 data engine done, bit 5 no target acknowledge, bit 4 oversize termination, bit 3 early termination, bit 2 arbitration loss, bit 1 target stop, bit 0 target event.
- R3: The enable for flag i sits at word bit i+8, and only that enable lets flag i raise `irq`.
- R4: A write to address 0x0 loads bits 7:0 into the flags and bits 15:8 into the enables.
- R5: A write to address 0x4 sets only the flag and enable bits written as 1 and leaves the others unchanged.
- R6: A write to address 0x8 clears only the flag and enable bits written as 1 and leaves the others unchanged.
- R7: When an event pulse and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: `irq` is registered. It goes high one cycle after the register holds a flag and its enable both at 1, and it goes low one cycle after no such pair remains.
- R9: Reads of 0x0, 0x4 and 0x8 all return the current word, with bits 31:16 read as 0. Address 0xC reads 0, and writes to it change nothing.
- R10: Writing 1 to bit 31 through 0x0 or 0x4 clears every flag and enable, including a flag from an event in that same cycle. Bit 31 written through 0x8 has no effect.
- R11: With no write and no event, the flags and the enables hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | NUM_EVT | One-cycle event pulses from the sequencer |
| bus_addr | input | ADDR_W | Byte address of the register bus |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: eight events, the enables starting at bit 8, a 4-bit address and the soft reset at bit 31. With the enable byte right next to the flag byte, a single write value covers both halves through every alias. The enable-to-flag pairing is walked bit by bit across all eight positions. An event and a clear, and an event and a soft reset, are driven in the same cycle to check which one wins.

// File: rtl/evt_csr_pkg.sv
// Package evt_csr_pkg
// Shared types for the event status register: the kind of access that an
// address selects, and the per-bit update rule for one access kind.
package evt_csr_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } csr_op_e;

    // Next value of one stored bit under a write of the given kind.
    function automatic logic apply_op(csr_op_e op, logic cur, logic wbit);
        logic r;
        case (op)
            OP_PLAIN: r = wbit;
            OP_SET:   r = cur | wbit;
            OP_CLR:   r = cur & ~wbit;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evt_csr_decode.sv
// Module evt_csr_decode
// Maps the byte address to an access kind (plain, set, clear, none), tells
// whether the current cycle carries a valid write, and flags a soft-reset
// request. Assumes word-aligned accesses: an address with nonzero low bits
// decodes to none, as do word indexes above 2.
module evt_csr_decode
    import evt_csr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              srst_bit,
    output csr_op_e           op,
    output logic              wr_valid,
    output logic              srst_req
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    assign word_idx = bus_addr[ADDR_W-1:2];

    // Select the alias from the word index; misaligned or unmapped is none.
    always_comb begin
        op = OP_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if (word_idx == WIDX_W'(0))      op = OP_PLAIN;
            else if (word_idx == WIDX_W'(1)) op = OP_SET;
            else if (word_idx == WIDX_W'(2)) op = OP_CLR;
        end
    end

    // Qualify the write strobe and pick out soft-reset writes.
    always_comb begin
        wr_valid = bus_we && (op != OP_NONE);
        srst_req = wr_valid && srst_bit && (op == OP_PLAIN || op == OP_SET);
    end

endmodule

// File: rtl/evt_csr_bank.sv
// Module evt_csr_bank
// A row of W stored bits updated through plain, set or clear writes. Each
// bit may also be forced to 1 by an event input, which overrides a write in
// the same cycle. A soft reset overrides both. Bits that take no events are
// fed an all-zero event vector.
module evt_csr_bank
    import evt_csr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         wr_valid,
    input  csr_op_e      op,
    input  logic [W-1:0] wbits,
    input  logic [W-1:0] evt,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    // Per-bit next value: write effect first, then the event forces a 1.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt[i] = (wr_valid ? apply_op(op, q[i], wbits[i]) : q[i]) | evt[i];
    end

    // Storage with synchronous reset and soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) q <= '0;
        else                q <= nxt;
    end

endmodule

// File: rtl/evt_csr_irq.sv
// Module evt_csr_irq
// Registers the OR of all flag/enable pairs into a single interrupt line.
// Assumes the flags and the enables are bit-aligned vectors of equal width.
module evt_csr_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flag,
    input  logic [W-1:0] en,
    output logic         irq
);

    // One register stage from the stored state to the output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag & en);
    end

endmodule

// File: rtl/evt_status_csr.sv
// Module evt_status_csr
// Event status word with plain, set and clear aliases. The flags sit at
// bits NUM_EVT-1:0, the enables at EN_LSB and up, and bit SRST_BIT is a
// self-clearing soft reset. Reads return the word for every alias and 0
// elsewhere. Assumes NUM_EVT <= EN_LSB, EN_LSB + NUM_EVT <= SRST_BIT,
// SRST_BIT < DATA_W and ADDR_W >= 4.
module evt_status_csr
    import evt_csr_pkg::*;
#(
    parameter int NUM_EVT  = 8,
    parameter int EN_LSB   = 8,
    parameter int SRST_BIT = 31,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq
);

    csr_op_e            op;
    logic               wr_valid;
    logic               srst_req;
    logic [NUM_EVT-1:0] flag_q;
    logic [NUM_EVT-1:0] en_q;
    logic               unused_wdata;

    // Only some write-data bits are stored; fold the rest away.
    assign unused_wdata = ^bus_wdata;

    evt_csr_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .srst_bit (bus_wdata[SRST_BIT]),
        .op       (op),
        .wr_valid (wr_valid),
        .srst_req (srst_req)
    );

    evt_csr_bank #(
        .W (NUM_EVT)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst_req),
        .wr_valid (wr_valid),
        .op       (op),
        .wbits    (bus_wdata[NUM_EVT-1:0]),
        .evt      (evt_pulse),
        .q        (flag_q)
    );

    evt_csr_bank #(
        .W (NUM_EVT)
    ) u_enables (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst_req),
        .wr_valid (wr_valid),
        .op       (op),
        .wbits    (bus_wdata[EN_LSB +: NUM_EVT]),
        .evt      ('0),
        .q        (en_q)
    );

    evt_csr_irq #(
        .W (NUM_EVT)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (flag_q),
        .en    (en_q),
        .irq   (irq)
    );

    // Read mux: the word for any alias, zero for unmapped addresses.
    always_comb begin
        bus_rdata = '0;
        if (op != OP_NONE) begin
            bus_rdata[NUM_EVT-1:0]      = flag_q;
            bus_rdata[EN_LSB +: NUM_EVT] = en_q;
        end
    end

endmodule

// File: rtl/evt_status_csr_chk.sv
// Module evt_status_csr_chk
// Temporal checks on the event status word, bound into evt_status_csr.
module evt_status_csr_chk
    import evt_csr_pkg::*;
#(
    parameter int NUM_EVT  = 8,
    parameter int EN_LSB   = 8,
    parameter int DATA_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt,
    input logic [NUM_EVT-1:0] flag_q,
    input logic [NUM_EVT-1:0] en_q,
    input logic               irq,
    input logic [DATA_W-1:0]  rdata,
    input logic               we,
    input logic               srst_req,
    input logic               wr_valid,
    input csr_op_e            op,
    input logic [DATA_W-1:0]  wdata
);

    localparam int HI_LSB = EN_LSB + NUM_EVT;

    // R2: an event leaves its flag set unless a soft reset came with it.
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt && !srst_req) |=> ((flag_q & $past(evt)) == $past(evt)));

    // R5: the set alias never clears a stored bit.
    assert_set_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && op == OP_SET && !srst_req) |=>
            ((flag_q & $past(flag_q)) == $past(flag_q)) &&
            ((en_q & $past(en_q)) == $past(en_q)));

    // R6: the clear alias never sets an enable.
    assert_clr_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && op == OP_CLR) |=> ((en_q & ~$past(en_q)) == '0));

    // R7: a same-cycle event survives a clear of its bit.
    assert_evt_beats_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && op == OP_CLR && |(evt & wdata[NUM_EVT-1:0])) |=>
            ((flag_q & $past(evt)) == $past(evt)));

    // R8: irq follows the stored flag/enable pairs one cycle later.
    assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(flag_q) & $past(en_q))));

    // R9: the upper bits of the read word are zero.
    assert_rdata_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:HI_LSB] == '0);

    // R10: a soft reset empties both banks.
    assert_srst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (flag_q == '0 && en_q == '0));

    // R11: with no write and no event the state holds.
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && evt == '0) |=> ($stable(flag_q) && $stable(en_q)));

endmodule

bind evt_status_csr evt_status_csr_chk #(
    .NUM_EVT (NUM_EVT),
    .EN_LSB  (EN_LSB),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .flag_q   (flag_q),
    .en_q     (en_q),
    .irq      (irq),
    .rdata    (bus_rdata),
    .we       (bus_we),
    .srst_req (srst_req),
    .wr_valid (wr_valid),
    .op       (op),
    .wdata    (bus_wdata)
);

// File: tb/evt_status_csr_tb.sv
// Scoreboard bench: the driver computes the expected read word and irq for
// every bus cycle and queues them; the monitor pops and compares them just
// after the clock edge that applies the cycle.
module evt_status_csr_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_pulse = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    exp_t        sb[$];
    logic [7:0]  mf = '0;
    logic [7:0]  me = '0;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_status_csr u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // One bus cycle: drive, update the model, queue the expected result.
    task automatic op(input logic [3:0] a, input logic we, input logic [31:0] wd,
                      input logic [7:0] ev, input string tag);
        exp_t e;
        logic [7:0] nf, ne;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; evt_pulse = ev;
        e.irq = |(mf & me);
        nf = mf; ne = me;
        if (we) begin
            case (a)
                4'h0: begin nf = wd[7:0];       ne = wd[15:8];        end
                4'h4: begin nf = nf | wd[7:0];  ne = ne | wd[15:8];   end
                4'h8: begin nf = nf & ~wd[7:0]; ne = ne & ~wd[15:8];  end
                default: ;
            endcase
        end
        nf = nf | ev;
        if (we && wd[31] && (a == 4'h0 || a == 4'h4)) begin nf = '0; ne = '0; end
        mf = nf; me = ne;
        e.rd  = (a == 4'h0 || a == 4'h4 || a == 4'h8) ? {16'h0, me, mf} : 32'h0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare the design against the queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (bus_rdata !== e.rd) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.rd);
                end
                checks++;
                if (irq !== e.irq) begin
                    failures++;
                    $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        op(4'h0, 0, 32'h0, 8'h00, "R1");
        // R2: events latch and stay
        op(4'h0, 0, 32'h0, 8'h81, "R2");
        op(4'h0, 0, 32'h0, 8'h00, "R11");
        // R9: every alias reads the word, unmapped reads zero
        op(4'h4, 0, 32'h0, 8'h00, "R9");
        op(4'h8, 0, 32'h0, 8'h00, "R9");
        op(4'hC, 0, 32'h0, 8'h00, "R9");
        // R5 / R3: set enable of bit 7 only
        op(4'h4, 1, 32'h0000_8000, 8'h00, "R5");
        op(4'h0, 0, 32'h0, 8'h00, "R8");
        // R7: event and clear of bit 7 in one cycle
        op(4'h8, 1, 32'h0000_0080, 8'h80, "R7");
        // R6: clear both flags, enable untouched
        op(4'h8, 1, 32'h0000_0081, 8'h00, "R6");
        op(4'h0, 0, 32'h0, 8'h00, "R8");
        // R4: plain load of both bytes
        op(4'h0, 1, 32'h0000_3C5A, 8'h00, "R4");
        // R9: write to unmapped address ignored, upper bits read zero
        op(4'hC, 1, 32'hFFFF_FFFF, 8'h00, "R9");
        op(4'h0, 0, 32'h0, 8'h00, "R9");
        op(4'h4, 1, 32'h7FFF_0000, 8'h00, "R9");
        op(4'h8, 1, 32'h0000_0F00, 8'h00, "R6");
        op(4'h0, 0, 32'h0, 8'h00, "R11");
        op(4'h0, 0, 32'h0, 8'h00, "R11");
        // R10: soft reset through set alias beats a same-cycle event
        op(4'h4, 1, 32'h8000_0000, 8'h01, "R10");
        op(4'h0, 1, 32'h0000_0101, 8'h00, "R4");
        op(4'h8, 1, 32'h8000_0000, 8'h00, "R10");
        op(4'h0, 0, 32'h0, 8'h00, "R8");
        op(4'h0, 1, 32'h8000_FFFF, 8'h00, "R10");
        // R3: walk the enable/flag pairing across all positions
        for (int i = 0; i < 8; i++) begin
            op(4'h0, 1, {16'h0, 8'(1 << i), 8'h00}, 8'h00, "R3");
            op(4'h0, 0, 32'h0, 8'(1 << ((i + 1) % 8)), "R3");
            op(4'h0, 0, 32'h0, 8'h00, "R3");
            op(4'h0, 0, 32'h0, 8'(1 << i), "R3");
            op(4'h0, 0, 32'h0, 8'h00, "R8");
            op(4'h0, 0, 32'h0, 8'h00, "R8");
        end
        @(negedge clk);
        bus_we = 1'b0; evt_pulse = '0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule